// File: doc/BRIEF.md
# Pixel Path Test Pattern Inserter

This block sits in the digital pixel path of an image sensor, between readout and the output serializer. A 9-bit mode input selects what leaves the block. The block can forward the live pixel stream unchanged, or it can replace that stream with synthetic data for debugging the system and the link. The synthetic patterns are a programmable solid Bayer colour, eight full-scale colour bars, the same bars fading toward mid-gray down the frame, a 9-bit pseudo-random link test sequence, and a walking-ones word at three widths.

The readout timing logic supplies frame-start, line-start, pixel-valid and embedded-row qualifiers, together with the pixel's column and row within the active area. The block registers one output word per input cycle with matching valid and embedded-row flags. Some patterns keep the embedded data rows and overwrite only the active pixels. The link test sequence removes those rows from the output altogether.

Top module: `tpg_top`

## Requirements
- R1: With mode code 0, every input word (active or embedded) appears at the output one clock later with the same data, valid and embedded flags.
- R2: Any mode code other than 0, 1, 2, 3, 4, 256, 257 and 258 behaves exactly as mode 0.
- R3: With mode 1, an active pixel outputs one of four programmable channel values, selected by {row[0], col[0]}: 00 gives Gr, 01 gives R, 10 gives B, 11 gives Gb.
- R4: With mode 2, the active width ACT_COLS is split into 8 bars of ACT_COLS/8 columns. Bar index = col/(ACT_COLS/8), clamped to 7. The bars are white, yellow, cyan, green, magenta, red, blue, black. Gr and Gb sites show the green component, R sites show red and B sites show blue. Each component is either full scale (all ones) or 0.
- R5: With mode 3, each bar value v is blended toward gray g = 2^(PIX_W-1). For v = full scale the output is v - floor((v-g)*r/(ACT_ROWS-1)). For v = 0 the output is floor(g*r/(ACT_ROWS-1)). Here r is the row, clamped to ACT_ROWS-1.
- R6: With modes 1, 2, 3, 256, 257 and 258, a word flagged as embedded is forwarded unchanged, with out_embedded high.
- R7: With mode 4, active words carry a sequence from s' = {s[7:0], s[8]^s[4]} (x^9+x^5+1). The output bit is s[8] before each shift, and bits are packed MSB-first, PIX_W per word. The state is seeded to all ones by frame_start, and that seed is used for a word in the same cycle. The state advances only on active words in this mode.
- R8: With mode 4, embedded words are dropped (out_valid low), and active words leave with out_embedded low.
- R9: With modes 256, 257 and 258, the word is 1 on the first active pixel of a line (line_start). It then shifts left once per active pixel and returns to 1 after bit 11, bit 9 or bit 7 respectively. Upper bits are zero.
- R10: After reset, out_valid, out_embedded and out_data are 0. out_valid is never high in a cycle that follows an input cycle without valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 9 | Pattern select code |
| solid_gr | input | PIX_W | Solid colour value for Gr sites |
| solid_r | input | PIX_W | Solid colour value for R sites |
| solid_b | input | PIX_W | Solid colour value for B sites |
| solid_gb | input | PIX_W | Solid colour value for Gb sites |
| in_frame_start | input | 1 | First word of a frame |
| in_line_start | input | 1 | First word of a line |
| in_valid | input | 1 | Input word is valid |
| in_embedded | input | 1 | Input word belongs to an embedded data row |
| in_col | input | COL_W | Active column of the word |
| in_row | input | ROW_W | Active row of the word |
| in_data | input | PIX_W | Live pixel data |
| out_valid | output | 1 | Output word is valid |
| out_embedded | output | 1 | Output word belongs to an embedded row |
| out_data | output | PIX_W | Output pixel word |

## Verification
Two pairs of functions can fall in the same cycle. In the link test, the frame-start reseed can coincide with the word that consumes the sequence. In the walking-ones modes, the line-start restart can coincide with a wrap or a shift. The bench runs two link-test frames back to back, so the second frame's first word arrives with frame_start while the state holds a mid-sequence value. That word must match the seed-derived word again. The walking-ones lines run past a wrap, and a new line_start arrives on a word that would otherwise shift, so the word must restart at 1.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    SEL_LIVE  = 3'd0,
    SEL_SOLID = 3'd1,
    SEL_BARS  = 3'd2,
    SEL_FADE  = 3'd3,
    SEL_PN9   = 3'd4,
    SEL_WALK  = 3'd5
  } tpg_sel_e;

  localparam int unsigned MODE_W   = 9;
  localparam int unsigned PN_LEN   = 9;
  localparam logic [PN_LEN-1:0] PN_SEED = '1;

  // Sparse code space mapped to a compact selector; unknown codes go live.
  function automatic tpg_sel_e decode_mode(input logic [MODE_W-1:0] code);
    case (code)
      9'd1:    return SEL_SOLID;
      9'd2:    return SEL_BARS;
      9'd3:    return SEL_FADE;
      9'd4:    return SEL_PN9;
      9'd256,
      9'd257,
      9'd258:  return SEL_WALK;
      default: return SEL_LIVE;
    endcase
  endfunction

  // Walking-ones MSB index: 256 -> 11, 257 -> 9, 258 -> 7.
  function automatic logic [3:0] walk_msb(input logic [MODE_W-1:0] code);
    case (code)
      9'd257:  return 4'd9;
      9'd258:  return 4'd7;
      default: return 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/tpg_bars.sv
module tpg_bars #(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned COL_W    = 12,
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned ACT_COLS = 64,
  parameter int unsigned ACT_ROWS = 8
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             fade,
  output logic [PIX_W-1:0] value
);

  localparam int unsigned BAR_W  = ACT_COLS / 8;
  localparam int unsigned PROD_W = PIX_W + ROW_W;
  localparam logic [PIX_W-1:0] FULL = '1;
  localparam logic [PIX_W-1:0] GRAY = PIX_W'(1) << (PIX_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ACT_ROWS - 1);

  logic [COL_W-1:0]  bar_q;
  logic [2:0]        bar;
  logic              comp_red, comp_grn, comp_blu, comp;
  logic [PIX_W-1:0]  base, delta, step;
  logic [ROW_W-1:0]  row_c;
  logic [PROD_W-1:0] prod, quot;

  always_comb begin
    bar_q = col / COL_W'(BAR_W);
    bar   = (bar_q > COL_W'(7)) ? 3'd7 : bar_q[2:0];
    // white yellow cyan green magenta red blue black
    comp_red = ~bar[1];
    comp_grn = ~bar[2];
    comp_blu = ~bar[0];
    case ({row[0], col[0]})
      2'b01:   comp = comp_red;
      2'b10:   comp = comp_blu;
      default: comp = comp_grn;
    endcase
    base  = comp ? FULL : '0;
    delta = comp ? (FULL - GRAY) : GRAY;
    row_c = (row > LAST_ROW) ? LAST_ROW : row;
    prod  = PROD_W'(delta) * PROD_W'(row_c);
    quot  = prod / PROD_W'(ACT_ROWS - 1);
    step  = quot[PIX_W-1:0];
    if (!fade)     value = base;
    else if (comp) value = base - step;
    else           value = base + step;
  end

endmodule

// File: rtl/tpg_pn9.sv
module tpg_pn9
  import tpg_pkg::*;
#(
  parameter int unsigned PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             advance,
  output logic [PIX_W-1:0] word
);

  logic [PN_LEN-1:0] state_q, state_d, cur, walk;

  always_comb begin
    cur  = frame_start ? PN_SEED : state_q;
    walk = cur;
    word = '0;
    for (int i = PIX_W - 1; i >= 0; i--) begin
      word[i] = walk[PN_LEN-1];
      walk    = {walk[PN_LEN-2:0], walk[8] ^ walk[4]};
    end
    if (advance)          state_d = walk;
    else if (frame_start) state_d = PN_SEED;
    else                  state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PN_SEED;
    else        state_q <= state_d;
  end

  // R7: a maximal-length register never falls into the all-zero lock state
  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/tpg_walk.sv
module tpg_walk #(
  parameter int unsigned PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             advance,
  input  logic [3:0]       msb,
  output logic [PIX_W-1:0] word
);

  logic [PIX_W-1:0] ones_q, ones_d;
  logic             wrap;

  always_comb begin
    word   = line_start ? PIX_W'(1) : ones_q;
    wrap   = |(word >> msb);
    if (advance)         ones_d = wrap ? PIX_W'(1) : (word << 1);
    else if (line_start) ones_d = PIX_W'(1);
    else                 ones_d = ones_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= PIX_W'(1);
    else        ones_q <= ones_d;
  end

  // R9: exactly one bit is set in the walking word at all times
  a_r9_single_one: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ones_q) == 1);

endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned COL_W    = 12,
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned ACT_COLS = 64,
  parameter int unsigned ACT_ROWS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        mode,
  input  logic [PIX_W-1:0]  solid_gr,
  input  logic [PIX_W-1:0]  solid_r,
  input  logic [PIX_W-1:0]  solid_b,
  input  logic [PIX_W-1:0]  solid_gb,
  input  logic              in_frame_start,
  input  logic              in_line_start,
  input  logic              in_valid,
  input  logic              in_embedded,
  input  logic [COL_W-1:0]  in_col,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [PIX_W-1:0]  in_data,
  output logic              out_valid,
  output logic              out_embedded,
  output logic [PIX_W-1:0]  out_data
);

  tpg_sel_e         sel;
  logic             active;
  logic             pn_adv, walk_adv;
  logic [PIX_W-1:0] bar_word, pn_word, walk_word, solid_word;
  logic [PIX_W-1:0] data_d;
  logic             valid_d, emb_d, data_en;
  logic [PIX_W-1:0] data_q;
  logic             valid_q, emb_q;

  assign sel      = decode_mode(mode);
  assign active   = in_valid & ~in_embedded;
  assign pn_adv   = active & (sel == SEL_PN9);
  assign walk_adv = active & (sel == SEL_WALK);

  tpg_bars #(
    .PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .ACT_COLS(ACT_COLS), .ACT_ROWS(ACT_ROWS)
  ) u_bars (
    .col   (in_col),
    .row   (in_row),
    .fade  (sel == SEL_FADE),
    .value (bar_word)
  );

  tpg_pn9 #(.PIX_W(PIX_W)) u_pn9 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (in_frame_start),
    .advance     (pn_adv),
    .word        (pn_word)
  );

  tpg_walk #(.PIX_W(PIX_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (in_line_start),
    .advance    (walk_adv),
    .msb        (walk_msb(mode)),
    .word       (walk_word)
  );

  always_comb begin
    case ({in_row[0], in_col[0]})
      2'b00:   solid_word = solid_gr;
      2'b01:   solid_word = solid_r;
      2'b10:   solid_word = solid_b;
      default: solid_word = solid_gb;
    endcase
  end

  // Next-state selection of the output word and its qualifiers
  always_comb begin
    valid_d = in_valid;
    emb_d   = in_embedded;
    data_d  = in_data;
    if (sel == SEL_PN9) begin
      valid_d = active;
      emb_d   = 1'b0;
      data_d  = pn_word;
    end else if (sel != SEL_LIVE && !in_embedded) begin
      case (sel)
        SEL_SOLID:         data_d = solid_word;
        SEL_BARS, SEL_FADE: data_d = bar_word;
        SEL_WALK:          data_d = walk_word;
        default:           data_d = in_data;
      endcase
    end
    data_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      emb_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      emb_q   <= emb_d & valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign out_valid    = valid_q;
  assign out_embedded = emb_q;
  assign out_data     = data_q;

  // R1: live mode forwards the word one cycle later
  a_r1_live_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 9'd0 && in_valid) |=> (out_valid && out_data == $past(in_data)));

  // R6: embedded rows survive the pixel-replacing patterns
  a_r6_embedded_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 9'd1 || mode == 9'd2 || mode == 9'd3) && in_valid && in_embedded)
      |=> (out_embedded && out_data == $past(in_data)));

  // R8: link test drops embedded rows
  a_r8_drop_embedded: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 9'd4 && in_embedded) |=> !out_valid);

  // R10: no output word without an input word
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: tb/tpg_top_test.sv
module tpg_top_test;

  localparam int PIX_W = 12;
  localparam int COL_W = 12;
  localparam int ROW_W = 12;
  localparam int COLS  = 64;
  localparam int ROWS  = 8;
  localparam int BARW  = COLS / 8;
  localparam int FULL  = (1 << PIX_W) - 1;
  localparam int GRAY  = 1 << (PIX_W - 1);

  logic clk, rst_n;
  logic [8:0] mode;
  logic [PIX_W-1:0] s_gr, s_r, s_b, s_gb;
  logic fs, ls, vld, emb;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [PIX_W-1:0] din;
  logic ov, oe;
  logic [PIX_W-1:0] od;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  tpg_top #(.PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W),
            .ACT_COLS(COLS), .ACT_ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .solid_gr(s_gr), .solid_r(s_r), .solid_b(s_b), .solid_gb(s_gb),
    .in_frame_start(fs), .in_line_start(ls), .in_valid(vld),
    .in_embedded(emb), .in_col(col), .in_row(row), .in_data(din),
    .out_valid(ov), .out_embedded(oe), .out_data(od)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one input cycle; return just after the capturing edge.
  task automatic push(input bit f, input bit l, input bit v, input bit e,
                      input int c, input int r, input int d);
    @(negedge clk);
    fs = f; ls = l; vld = v; emb = e;
    col = COL_W'(c); row = ROW_W'(r); din = PIX_W'(d);
    @(posedge clk);
    #1;
  endtask

  function automatic int bar_ref(input int c, input int r, input bit fade);
    int b, comp, rr;
    b = c / BARW; if (b > 7) b = 7;
    case ({r[0], c[0]})
      2'b01:   comp = ((b >> 1) & 1) == 0;
      2'b10:   comp = (b & 1) == 0;
      default: comp = ((b >> 2) & 1) == 0;
    endcase
    rr = (r > ROWS - 1) ? ROWS - 1 : r;
    if (!fade) return comp ? FULL : 0;
    if (comp) return FULL - ((FULL - GRAY) * rr) / (ROWS - 1);
    return (GRAY * rr) / (ROWS - 1);
  endfunction

  logic [8:0] pn_s;
  function automatic int pn_next_word();
    int w = 0;
    for (int i = PIX_W - 1; i >= 0; i--) begin
      w = w | (int'(pn_s[8]) << i);
      pn_s = {pn_s[7:0], pn_s[8] ^ pn_s[4]};
    end
    return w;
  endfunction

  task automatic t_reset();
    chk(ov, 0, "R10 reset valid");
    chk(oe, 0, "R10 reset embedded");
    chk(od, 0, "R10 reset data");
  endtask

  task automatic t_live();
    mode = 9'd0;
    push(1, 1, 1, 1, 0, 0, 12'h5A5);
    chk(ov, 1, "R1 valid emb"); chk(oe, 1, "R1 emb flag"); chk(od, 12'h5A5, "R1 emb data");
    push(0, 1, 1, 0, 0, 0, 12'h123);
    chk(oe, 0, "R1 active flag"); chk(od, 12'h123, "R1 active data");
    push(0, 0, 0, 0, 1, 0, 12'hFFF);
    chk(ov, 0, "R10 idle gap");
  endtask

  task automatic t_unsupported();
    int codes[3] = '{5, 300, 259};
    foreach (codes[k]) begin
      mode = 9'(codes[k]);
      push(0, 0, 1, 0, 3, 1, 12'h0F0 + k);
      chk(od, 12'h0F0 + k, "R2 passthrough data");
      chk(ov, 1, "R2 passthrough valid");
    end
  endtask

  task automatic t_solid();
    mode = 9'd1;
    s_gr = 12'h111; s_r = 12'h222; s_b = 12'h333; s_gb = 12'h444;
    push(0, 1, 1, 0, 0, 0, 0); chk(od, 12'h111, "R3 Gr");
    push(0, 0, 1, 0, 1, 0, 0); chk(od, 12'h222, "R3 R");
    push(0, 1, 1, 0, 0, 1, 0); chk(od, 12'h333, "R3 B");
    push(0, 0, 1, 0, 1, 1, 0); chk(od, 12'h444, "R3 Gb");
  endtask

  task automatic t_bars();
    mode = 9'd2;
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 2; p++) begin
          push(0, 0, 1, 0, b * BARW + 2 + p, r, 0);
          chk(od, bar_ref(b * BARW + 2 + p, r, 0), "R4 bar value");
        end
    push(0, 0, 1, 0, COLS + 5, 0, 0);
    chk(od, bar_ref(COLS + 5, 0, 0), "R4 clamp");
  endtask

  task automatic t_fade();
    int rows[4] = '{0, 3, ROWS - 1, ROWS + 2};
    mode = 9'd3;
    foreach (rows[k])
      for (int c = 0; c < COLS; c += 7) begin
        push(0, 0, 1, 0, c, rows[k], 0);
        chk(od, bar_ref(c, rows[k], 1), "R5 fade value");
      end
  endtask

  task automatic t_embedded();
    int ms[4] = '{1, 2, 3, 257};
    foreach (ms[k]) begin
      mode = 9'(ms[k]);
      push(0, 1, 1, 1, 4, 0, 12'hA00 + k);
      chk(od, 12'hA00 + k, "R6 embedded data");
      chk(oe, 1, "R6 embedded flag");
    end
  endtask

  task automatic t_pn9();
    int w;
    mode = 9'd4;
    for (int f = 0; f < 2; f++) begin
      pn_s = 9'h1FF;
      push(1, 1, 1, 1, 0, 0, 12'h777);
      chk(ov, 0, "R8 embedded dropped");
      for (int c = 0; c < 20; c++) begin
        w = pn_next_word();
        push(0, c == 0, 1, 0, c, 0, 12'h777);
        chk(od, w, "R7 pn word");
        chk(oe, 0, "R8 embedded low");
      end
    end
    // back-to-back frame: reseed on a consuming word
    pn_s = 9'h1FF;
    w = pn_next_word();
    push(1, 1, 1, 0, 0, 0, 0);
    chk(od, w, "R7 reseed same cycle");
  endtask

  task automatic t_walk();
    int codes[3] = '{256, 257, 258};
    int msbs[3]  = '{11, 9, 7};
    int exp;
    foreach (codes[k]) begin
      mode = 9'(codes[k]);
      exp = 1;
      for (int c = 0; c < 15; c++) begin
        push(0, c == 0, 1, 0, c, 0, 0);
        chk(od, exp, "R9 walk word");
        exp = (exp >> msbs[k]) != 0 ? 1 : exp << 1;
      end
      push(0, 1, 1, 0, 0, 1, 0);
      chk(od, 1, "R9 line restart");
    end
  endtask

  initial begin
    rst_n = 0; mode = 0; fs = 0; ls = 0; vld = 0; emb = 0;
    col = 0; row = 0; din = 0; s_gr = 0; s_r = 0; s_b = 0; s_gb = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_live();
    t_unsupported();
    t_solid();
    t_bars();
    t_fade();
    t_embedded();
    t_pn9();
    t_walk();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule